// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper for One H-Bridge

This block sequences the four switches of a single H-bridge so that the peak load current stays bounded. It runs each chopping cycle with a constant off interval rather than a constant period. An external comparator raises a digital trip flag when the sensed current reaches its limit. The block then turns off only the conducting high-side (source) switch for a programmed number of clock cycles. The diagonal low-side (sink) switch stays on, so the current decays slowly by recirculating through the low side. Once the off interval ends, the source switch conducts again.

Every switching event is followed by a blanking window in which the trip flag is ignored: the end of an off interval, the end of a direction change, and a re-enable. This gives a minimum on-time and masks switching spikes. The blanking length is not a separate setting; it is derived from the off-time setting. A direction change first passes through a dead interval with every switch off, so the two switches on one side never conduct together. Deasserting the enable input forces every switch off and clears the timing state.

The off-time and dead-time counts are captured while reset is held. A state code output lets a testbench follow the sequence.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `state_o` is 0 (disabled) and all four gate outputs are low. State codes: 0 disabled, 1 crossover, 2 blank-on, 3 on, 4 off-time.
- R2: If `enable_i` is low at a clock edge, the state after that edge is disabled and all gates are low.
- R3: On the first edge with `enable_i` high after the disabled state, the block enters blank-on, latching `phase_i` as the direction, and the gates drive that direction at once.
- R4: Direction high drives `src_a_o` and `snk_b_o`; direction low drives `src_b_o` and `snk_a_o`. A source and a sink on the same side are never high in the same cycle.
- R5: `trip_i` passes through a two-flop synchronizer. A trip present in the on state moves the block to off-time, which turns the source off and keeps the diagonal sink on. A trip level sampled at edge k changes the state at edge k+2.
- R6: Off-time lasts exactly the captured off count in cycles, then blank-on follows with the same direction.
- R7: Blank-on lasts max(1, off count >> BLANK_SHIFT) cycles (2 cycles for an off count of 4 with the default shift of 1) before the on state. A trip seen only during blank-on or off-time is dropped and does not end the following on state.
- R8: A change of `phase_i` in blank-on, on or off-time enters crossover with all gates low for exactly the captured crossover count in cycles. The block then enters blank-on in the new direction.
- R9: The counts are taken from `off_cycles_i` and `xover_cycles_i` only while reset is high, and later changes have no effect. A count of zero behaves as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; captures the counts |
| enable_i | input | 1 | Bridge enable; low forces every switch off |
| phase_i | input | 1 | Requested current direction |
| trip_i | input | 1 | Over-current flag from the external comparator |
| off_cycles_i | input | CNT_W | Off-time length in cycles |
| xover_cycles_i | input | CNT_W | Crossover dead time in cycles |
| src_a_o | output | 1 | Side A source switch command |
| snk_a_o | output | 1 | Side A sink switch command |
| src_b_o | output | 1 | Side B source switch command |
| snk_b_o | output | 1 | Side B sink switch command |
| state_o | output | 3 | Current state code |

## Verification
The hardest case to reach is a trip that arrives during the last cycle of an off interval. It must cross the synchronizer and land inside the following blank-on window, where it has to be dropped rather than remembered. The stimulus pulses the trip one cycle early, timed against the synchronizer delay, so that it reaches the state logic exactly in blank-on. The bench then checks that the on state holds for two more cycles. Zero-count behaviour is reached by a second reset with zero counts, which gives one-cycle off, blank and crossover windows.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_DIS   = 3'd0,
        ST_XOVER = 3'd1,
        ST_BLANK = 3'd2,
        ST_ON    = 3'd3,
        ST_OFF   = 3'd4
    } chop_state_e;

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)              cnt_d = '0;
        else if (load)        cnt_d = load_val;
        else if (cnt_q > ONE) cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == ONE);

    AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
    import chop_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_SHIFT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             phase_i,
    input  logic             trip_i,
    input  logic [CNT_W-1:0] off_cycles_i,
    input  logic [CNT_W-1:0] xover_cycles_i,
    output logic             src_a_o,
    output logic             snk_a_o,
    output logic             src_b_o,
    output logic             snk_b_o,
    output logic [2:0]       state_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        chop_state_e      st;
        logic             dir;
        logic [CNT_W-1:0] off_len;
        logic [CNT_W-1:0] blank_len;
        logic [CNT_W-1:0] xov_len;
    } ctrl_t;

    ctrl_t            r_d, r_q;
    logic             trip_s;
    logic             tmr_done;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (trip_i),
        .dout (trip_s)
    );

    chop_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (!enable_i),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!enable_i) begin
            r_d.st = ST_DIS;
        end else begin
            case (r_q.st)
                ST_DIS: begin
                    r_d.st   = ST_BLANK;
                    r_d.dir  = phase_i;
                    tmr_load = 1'b1;
                    tmr_val  = r_q.blank_len;
                end
                ST_XOVER: begin
                    if (tmr_done) begin
                        r_d.st   = ST_BLANK;
                        r_d.dir  = phase_i;
                        tmr_load = 1'b1;
                        tmr_val  = r_q.blank_len;
                    end
                end
                default: begin
                    if (phase_i != r_q.dir) begin
                        r_d.st   = ST_XOVER;
                        tmr_load = 1'b1;
                        tmr_val  = r_q.xov_len;
                    end else if (r_q.st == ST_BLANK) begin
                        if (tmr_done) r_d.st = ST_ON;
                    end else if (r_q.st == ST_ON) begin
                        if (trip_s) begin
                            r_d.st   = ST_OFF;
                            tmr_load = 1'b1;
                            tmr_val  = r_q.off_len;
                        end
                    end else begin
                        if (tmr_done) begin
                            r_d.st   = ST_BLANK;
                            tmr_load = 1'b1;
                            tmr_val  = r_q.blank_len;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st        <= ST_DIS;
            r_q.dir       <= 1'b0;
            r_q.off_len   <= at_least_one(off_cycles_i);
            r_q.blank_len <= at_least_one(off_cycles_i >> BLANK_SHIFT);
            r_q.xov_len   <= at_least_one(xover_cycles_i);
        end else begin
            r_q <= r_d;
        end
    end

    logic drive_src, drive_snk;
    always_comb begin
        drive_src = (r_q.st == ST_BLANK) || (r_q.st == ST_ON);
        drive_snk = drive_src || (r_q.st == ST_OFF);
        src_a_o   = drive_src &&  r_q.dir;
        snk_b_o   = drive_snk &&  r_q.dir;
        src_b_o   = drive_src && !r_q.dir;
        snk_a_o   = drive_snk && !r_q.dir;
        state_o   = r_q.st;
    end

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (state_o == ST_DIS && !src_a_o && !src_b_o && !snk_a_o && !snk_b_o)); // R2

    AST_SAME_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(src_a_o && snk_a_o) && !(src_b_o && snk_b_o)); // R4

    AST_TRIP_CHOPS: assert property (@(posedge clk) disable iff (rst)
        (enable_i && r_q.st == ST_ON && phase_i == r_q.dir && trip_s)
        |=> (r_q.st == ST_OFF && !src_a_o && !src_b_o && $stable(r_q.dir))); // R5

    AST_BLANK_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (enable_i && r_q.st == ST_BLANK && phase_i == r_q.dir && !tmr_done)
        |=> (r_q.st == ST_BLANK)); // R7

    AST_DIR_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (enable_i && phase_i != r_q.dir &&
         (r_q.st == ST_BLANK || r_q.st == ST_ON || r_q.st == ST_OFF))
        |=> (r_q.st == ST_XOVER)); // R8

    AST_REENABLE_BLANK: assert property (@(posedge clk) disable iff (rst)
        (enable_i && r_q.st == ST_DIS) |=> (r_q.st == ST_BLANK)); // R3

endmodule

// File: tb/chop_bridge_ctrl_tb.sv
module chop_bridge_ctrl_tb;
    localparam int CNT_W = 8;
    localparam int NVEC  = 27;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable_i = 1'b0;
    logic             phase_i = 1'b1;
    logic             trip_i = 1'b0;
    logic [CNT_W-1:0] off_cycles_i = 8'd4;
    logic [CNT_W-1:0] xover_cycles_i = 8'd3;
    logic             src_a_o, snk_a_o, src_b_o, snk_b_o;
    logic [2:0]       state_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    chop_bridge_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .enable_i       (enable_i),
        .phase_i        (phase_i),
        .trip_i         (trip_i),
        .off_cycles_i   (off_cycles_i),
        .xover_cycles_i (xover_cycles_i),
        .src_a_o        (src_a_o),
        .snk_a_o        (snk_a_o),
        .src_b_o        (src_b_o),
        .snk_b_o        (snk_b_o),
        .state_o        (state_o)
    );

    // row: {enable, phase, trip, expected state[2:0], expected {src_a,snk_a,src_b,snk_b}}
    // off=4, xover=3, blank=2; tags per row in the comments
    localparam logic [9:0] VEC [NVEC] = '{
        {3'b010, 3'd0, 4'b0000},  // 0  R1 disabled after reset
        {3'b110, 3'd2, 4'b1001},  // 1  R3 enable -> blank-on, R4 dir high
        {3'b110, 3'd2, 4'b1001},  // 2  R7 blank 2 cycles
        {3'b110, 3'd3, 4'b1001},  // 3  on
        {3'b111, 3'd3, 4'b1001},  // 4  R5 trip raised
        {3'b110, 3'd3, 4'b1001},  // 5  synchronizer delay
        {3'b110, 3'd4, 4'b0001},  // 6  R5 off-time, sink held
        {3'b110, 3'd4, 4'b0001},  // 7  R6
        {3'b110, 3'd4, 4'b0001},  // 8  R6
        {3'b111, 3'd4, 4'b0001},  // 9  R6 last off cycle, R7 late trip pulse
        {3'b110, 3'd2, 4'b1001},  // 10 R7 blank
        {3'b110, 3'd2, 4'b1001},  // 11 R7 trip dropped here
        {3'b110, 3'd3, 4'b1001},  // 12 R7 on
        {3'b110, 3'd3, 4'b1001},  // 13 R7 trip not stored
        {3'b100, 3'd1, 4'b0000},  // 14 R8 crossover
        {3'b100, 3'd1, 4'b0000},  // 15 R8
        {3'b100, 3'd1, 4'b0000},  // 16 R8
        {3'b100, 3'd2, 4'b0110},  // 17 R8 blank, R4 dir low
        {3'b100, 3'd2, 4'b0110},  // 18 R7
        {3'b100, 3'd3, 4'b0110},  // 19 on
        {3'b000, 3'd0, 4'b0000},  // 20 R2 disable
        {3'b100, 3'd2, 4'b0110},  // 21 R3 re-enable
        {3'b100, 3'd2, 4'b0110},  // 22 R3
        {3'b100, 3'd3, 4'b0110},  // 23 on
        {3'b101, 3'd3, 4'b0110},  // 24 R5 trip, dir low
        {3'b100, 3'd3, 4'b0110},  // 25
        {3'b100, 3'd4, 4'b0100}   // 26 R5 off-time keeps sink A
    };

    task automatic check(input logic [2:0] exp_st, input logic [3:0] exp_g, input string req);
        logic [3:0] g;
        g = {src_a_o, snk_a_o, src_b_o, snk_b_o};
        n_chk++;
        if (state_o !== exp_st || g !== exp_g) begin
            n_bad++;
            $display("FAIL %s: state=%0d gates=%b expected state=%0d gates=%b",
                     req, state_o, g, exp_st, exp_g);
        end
        n_chk++;
        if ((src_a_o && snk_a_o) || (src_b_o && snk_b_o)) begin
            n_bad++;
            $display("FAIL R4: same-side conduction gates=%b expected no side with both on", g);
        end
    endtask

    task automatic step(input logic en, input logic ph, input logic tr,
                        input logic [2:0] exp_st, input logic [3:0] exp_g, input string req);
        enable_i = en;
        phase_i  = ph;
        trip_i   = tr;
        @(negedge clk);
        check(exp_st, exp_g, req);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, enable high during reset has no effect
        enable_i = 1'b1;
        repeat (3) @(negedge clk);
        check(3'd0, 4'b0000, "R1");
        enable_i = 1'b0;
        rst = 1'b0;
        // R9: counts changed after reset must be ignored
        off_cycles_i   = 8'd9;
        xover_cycles_i = 8'd7;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6:4], VEC[i][3:0],
                 $sformatf("row %0d R1..R9 (see row tag)", i));
        end

        // R9: zero counts behave as one cycle
        enable_i       = 1'b0;
        off_cycles_i   = 8'd0;
        xover_cycles_i = 8'd0;
        rst            = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b1, 1'b0, 3'd2, 4'b1001, "R9 zero blank");
        step(1'b1, 1'b1, 1'b1, 3'd3, 4'b1001, "R9 on after 1-cycle blank");
        step(1'b1, 1'b1, 1'b0, 3'd3, 4'b1001, "R5 sync delay");
        step(1'b1, 1'b1, 1'b0, 3'd4, 4'b0001, "R5 zero-count off");
        step(1'b1, 1'b1, 1'b0, 3'd2, 4'b1001, "R9 one-cycle off");
        step(1'b1, 1'b1, 1'b0, 3'd3, 4'b1001, "R9 one-cycle blank");
        step(1'b1, 1'b0, 1'b0, 3'd1, 4'b0000, "R8 crossover");
        step(1'b1, 1'b0, 1'b0, 3'd2, 4'b0110, "R9 one-cycle crossover");
        step(1'b0, 1'b0, 1'b0, 3'd0, 4'b0000, "R2 disable");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule